// File: doc/BRIEF.md
# Dual external interrupt flag controller

This block turns two active-low external interrupt lines into request flags for a CPU core. Each line has its own sensitivity select. In level mode a low line sets its flag. In falling-edge mode only a high-to-low change sets it. The line value the block looks at is the synchronized pin input ANDed with that pin's port output latch bit. Clearing the latch bit therefore pulls the line low inside the block.

The flags and the sensitivity selects sit in a control byte. A second byte holds a per-source enable and a global enable. When an enabled flag is pending, the block raises a request toward the core along with a fixed vector address. Source 0 wins over source 1. When the core acknowledges, the block clears the flag of the source it was presenting. Software can set or clear either flag by writing the control byte. For one cycle after any write to the enable byte, the request output is held off.

Top module: `exti_ctrl`

## Requirements
- R1: After reset the control byte and the enable byte both read 0x00 and `irq_req` is low.
- R2: With its type bit at 0 (level mode), a source's flag is set at every clock edge where its effective line is low. The flag stays set after the line returns high. An acknowledge clears the flag, but the flag sets again at the same edge if the line is still low.
- R3: With its type bit at 1 (edge mode), a flag is set only at an edge where the previous sample of the effective line was high and the current sample is low. After an acknowledge, a line that stays low does not set the flag again.
- R4: The effective line of source i is `pin_in[i] & port_latch[i]`. A latch bit of 0 acts as a low line even while the pin is high.
- R5: While `irq_req` is high, `irq_vec` is 0x0003 when source 0 is being presented and 0x0013 when source 1 is being presented.
- R6: `irq_req` is high only when the global enable (enable byte bit 7) is 1 and at least one flag is pending whose own enable is also 1. The enable for source 0 is bit 0 and the enable for source 1 is bit 2.
- R7: When both enabled flags are pending, source 0 is presented first. An acknowledge clears only the presented flag, after which source 1 is presented.
- R8: A control byte write changes the type bits at once, but the new mode is applied from the next sample on. The sample taken at the same edge as the write still uses the old mode.
- R9: A control byte write loads the flag bits directly: bit 1 is flag 0 and bit 3 is flag 1, while bits 0 and 2 are type 0 and type 1. A hardware set at the same edge takes precedence over a written 0.
- R10: In the cycle after any write to the enable byte, `irq_req` is low. It returns on the following cycle if a request is still valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control/flag byte, 1 = enable byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pin_in | input | 2 | Synchronized external lines, active low |
| port_latch | input | 2 | Port output latch bits that gate the lines |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Vector address of the presented source |
| irq_ack | input | 1 | Core acknowledge of the presented source |

## Verification
The case that is hardest to reach from the ports is a control write that lands on the same edge as a level-mode sample while the line is held low. That edge must still apply the old mode and must let the hardware set win over the written 0. The stimulus holds source 0 low in level mode and writes edge mode with a cleared flag. The flag should still read 1 after that write. A second identical write should leave it clear, because the mode is now edge and no new edge occurs. A separate sequence acknowledges a level-mode source while its line stays low, to show that the flag sets again at once.

// File: rtl/exti_pkg.sv
package exti_pkg;
    localparam int N_SRC      = 2;
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 16;
    localparam int EA_BIT     = 7;

    typedef struct packed {
        logic typ;
        logic flag;
        logic prev;
    } src_state_t;
endpackage

// File: rtl/exti_src.sv
module exti_src (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic wr_ctl,
    input  logic wr_type,
    input  logic wr_flag,
    input  logic ack,
    output logic flag_o,
    output logic type_o
);
    import exti_pkg::*;

    src_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        // mode in force is the registered one; a write applies from the next sample
        hit  = st_q.typ ? (st_q.prev & ~line) : ~line;
        if (wr_ctl) begin
            st_d.typ  = wr_type;
            st_d.flag = wr_flag;
        end else if (ack) begin
            st_d.flag = 1'b0;
        end
        st_d.flag = st_d.flag | hit;
        st_d.prev = line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{typ: 1'b0, flag: 1'b0, prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign type_o = st_q.typ;
endmodule

// File: rtl/exti_arb.sv
module exti_arb #(
    parameter int N     = 2,
    parameter int VW    = 16,
    parameter int BASE  = 3,
    parameter int STEP  = 16
) (
    input  logic [N-1:0]  pend,
    input  logic          hold,
    output logic          req,
    output logic [VW-1:0] vec,
    output logic [N-1:0]  grant
);
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                vec = VW'(BASE + STEP * i);
            end
        end
        req = (|pend) & ~hold;
        if (!req) begin
            grant = '0;
        end
    end
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [N_SRC-1:0] pin_in,
    input  logic [N_SRC-1:0] port_latch,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic             ea;
        logic             hold;
    } en_state_t;

    en_state_t        es_d, es_q;
    logic [N_SRC-1:0] flag_q, type_q, pend, grant;
    logic             wr_ctl, wr_en;

    assign wr_ctl = reg_we & ~reg_sel;
    assign wr_en  = reg_we &  reg_sel;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        exti_src u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .line    (pin_in[i] & port_latch[i]),
            .wr_ctl  (wr_ctl),
            .wr_type (reg_wdata[2*i]),
            .wr_flag (reg_wdata[2*i+1]),
            .ack     (irq_ack & grant[i]),
            .flag_o  (flag_q[i]),
            .type_o  (type_q[i])
        );
    end

    always_comb begin
        es_d      = es_q;
        es_d.hold = wr_en;
        if (wr_en) begin
            es_d.ea = reg_wdata[EA_BIT];
            for (int i = 0; i < N_SRC; i++) begin
                es_d.en[i] = reg_wdata[2*i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            es_q <= '0;
        end else begin
            es_q <= es_d;
        end
    end

    assign pend = flag_q & es_q.en & {N_SRC{es_q.ea}};

    exti_arb #(
        .N    (N_SRC),
        .VW   (VEC_W),
        .BASE (VEC_BASE),
        .STEP (VEC_STRIDE)
    ) u_arb (
        .pend  (pend),
        .hold  (es_q.hold),
        .req   (irq_req),
        .vec   (irq_vec),
        .grant (grant)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (reg_sel) begin
                reg_rdata[2*i]   = es_q.en[i];
            end else begin
                reg_rdata[2*i]   = type_q[i];
                reg_rdata[2*i+1] = flag_q[i];
            end
        end
        if (reg_sel) begin
            reg_rdata[EA_BIT] = es_q.ea;
        end
    end
endmodule

// File: rtl/exti_ctrl_chk.sv
module exti_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic        reg_sel,
    input logic [1:0]  pin_in,
    input logic [1:0]  port_latch,
    input logic        irq_req,
    input logic [15:0] irq_vec,
    input logic [1:0]  flag_q,
    input logic [1:0]  type_q,
    input logic [1:0]  en_bits,
    input logic        ea_bit
);
    logic eff0;
    assign eff0 = pin_in[0] & port_latch[0];

    assert_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (ea_bit && |(flag_q & en_bits)));

    assert_hold_after_en_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> !irq_req);

    assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == 16'h0003 || irq_vec == 16'h0013));

    assert_src0_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && flag_q[0] && en_bits[0]) |-> (irq_vec == 16'h0003));

    assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!type_q[0] && !eff0 && !(reg_we && !reg_sel)) |=> flag_q[0]);

    assert_edge_no_retrigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (type_q[0] && !flag_q[0] && !eff0 && $past(!eff0) && !reg_we) |=> !flag_q[0]);
endmodule

bind exti_ctrl exti_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .pin_in     (pin_in),
    .port_latch (port_latch),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .flag_q     (flag_q),
    .type_q     (type_q),
    .en_bits    (es_q.en),
    .ea_bit     (es_q.ea)
);

// File: tb/tb_exti_ctrl.sv
`timescale 1ns/1ps
module tb_exti_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [1:0]  pin_in = 2'b11;
    logic [1:0]  port_latch = 2'b11;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    exti_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .port_latch(port_latch), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk("R1 ctl", 16'(v), 16'h00);
        rd(1'b1, v); chk("R1 en", 16'(v), 16'h00);
        chk("R1 req", 16'(irq_req), 16'h0);
    endtask

    task automatic t_level();
        logic [7:0] v;
        pin_in[0] = 1'b0; tick(); pin_in[0] = 1'b1; tick();
        rd(1'b0, v); chk("R2 sticky flag", 16'(v), 16'h02);
        wr(1'b1, 8'h81); tick();
        chk("R5 req", 16'(irq_req), 16'h1);
        chk("R5 vec0", irq_vec, 16'h0003);
        ack();
        rd(1'b0, v); chk("R2 ack clears", 16'(v), 16'h00);
        chk("R2 req off", 16'(irq_req), 16'h0);
        pin_in[0] = 1'b0; tick();
        ack();
        rd(1'b0, v); chk("R2 reset while low", 16'(v), 16'h02);
        pin_in[0] = 1'b1; tick();
        ack();
        rd(1'b0, v); chk("R2 clear after high", 16'(v), 16'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] v;
        wr(1'b0, 8'h01);
        pin_in[0] = 1'b0; tick();
        rd(1'b0, v); chk("R3 edge sets", 16'(v), 16'h03);
        wr(1'b0, 8'h01); tick(2);
        rd(1'b0, v); chk("R3 no retrigger low", 16'(v), 16'h01);
        pin_in[0] = 1'b1; tick();
        pin_in[0] = 1'b0; tick();
        rd(1'b0, v); chk("R3 second edge", 16'(v), 16'h03);
        pin_in[0] = 1'b1;
        wr(1'b0, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        port_latch[0] = 1'b0; tick();
        port_latch[0] = 1'b1;
        rd(1'b0, v); chk("R4 latch0 gates", 16'(v), 16'h02);
        wr(1'b0, 8'h00);
        port_latch[1] = 1'b0; tick();
        port_latch[1] = 1'b1;
        rd(1'b0, v); chk("R4 latch1 gates", 16'(v), 16'h08);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R4 pin high latch high", 16'(v), 16'h00);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R9 both flags written", 16'(v), 16'h0A);
        wr(1'b1, 8'h85); tick();
        chk("R7 req", 16'(irq_req), 16'h1);
        chk("R7 src0 first", irq_vec, 16'h0003);
        ack();
        rd(1'b0, v); chk("R7 only flag0 cleared", 16'(v), 16'h08);
        chk("R5 vec1", irq_vec, 16'h0013);
        ack();
        rd(1'b0, v); chk("R7 flag1 cleared", 16'(v), 16'h00);
        chk("R7 req off", 16'(irq_req), 16'h0);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr(1'b0, 8'h0A);
        wr(1'b1, 8'h05); tick();
        chk("R6 no global", 16'(irq_req), 16'h0);
        wr(1'b1, 8'h84); tick();
        rd(1'b1, v); chk("R6 en readback", 16'(v), 16'h84);
        chk("R6 src0 masked", irq_vec, 16'h0013);
        chk("R6 req src1", 16'(irq_req), 16'h1);
        wr(1'b1, 8'h80); tick();
        chk("R6 none enabled", 16'(irq_req), 16'h0);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_hold();
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h81);
        chk("R10 held", 16'(irq_req), 16'h0);
        tick();
        chk("R10 released", 16'(irq_req), 16'h1);
        wr(1'b1, 8'h81);
        chk("R10 held again", 16'(irq_req), 16'h0);
        tick();
        chk("R10 back", 16'(irq_req), 16'h1);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_mode();
        logic [7:0] v;
        pin_in[0] = 1'b0; tick();
        wr(1'b0, 8'h01);
        rd(1'b0, v); chk("R8 old mode at write edge", 16'(v), 16'h03);
        wr(1'b0, 8'h01);
        rd(1'b0, v); chk("R8 new mode next sample", 16'(v), 16'h01);
        tick();
        rd(1'b0, v); chk("R8 stays clear", 16'(v), 16'h01);
        pin_in[0] = 1'b1;
        wr(1'b0, 8'h00);
    endtask

    task automatic t_sw();
        logic [7:0] v;
        wr(1'b0, 8'h08);
        rd(1'b0, v); chk("R9 sw set flag1", 16'(v), 16'h08);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R9 sw clear flag1", 16'(v), 16'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_level();
        t_edge();
        t_latch();
        t_prio();
        t_enable();
        t_hold();
        t_mode();
        t_sw();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule